// File: doc/BRIEF.md
# Repeated Picture-Window Position Generator

This block decides, pixel by pixel, whether the current point of a video field lies inside one of a grid of repeated inset pictures. It counts pixels from each line-sync pulse and lines from each field-sync pulse. It compares those counts against up to four rows of windows. Each row holds up to four windows. It reports whether a window is active, which window it is, and the pixel and line position inside that window. A memory read stage downstream uses these to address the stored picture.

Each row has its own horizontal pitch, its own first grid slot and its own count of extra windows. The windows on a row may only use grid slots 0 to 3, counted from the left edge. Every window has the same width and height. Rows are spaced by a common vertical pitch. A mode bit selects line doubling of the height and the larger acquisition area for 50 Hz video.

All settings are copied into shadow registers on field sync, so a field never mixes old and new settings.

Top module: `pip_grid_gen`

## Requirements
- R1: After reset, and until the first field sync, `winActive`, `winIndex`, `winX` and `winY` are all 0.
- R2: While a window is active, `winX` is the pixel count minus that window's start pixel and `winY` is the line count minus that row's top line. The pixel count is 0 on the cycle after a line or field sync and then rises by one per clock. The line count is 0 after a field sync and rises by one at each line sync. All other outputs are 0 when no window is active.
- R3: A window covers 4×`picWidth` pixels, starting at its start pixel. A width of 0 shows nothing.
- R4: A window covers `picHeight` lines when `palMode`=0 and 2×`picHeight` lines when `palMode`=1.
- R5: The window in grid slot g of row r starts at pixel g×4×pitch(r). Its index is r×4+g. Pitch(r) is `rowPitch[8r+7:8r]`.
- R6: Row r shows the slots from offset(r) to offset(r)+repeat(r), and never a slot above 3. Offset(r) is `rowOffset[2r+1:2r]` and repeat(r) is `rowRepeat[2r+1:2r]`.
- R7: Exactly `rowCount`+1 rows are shown. Row r starts at line r×`rowDist`.
- R8: When the latched channel enable is 0, no window is active.
- R9: No window is active on line 228 or later when `palMode`=0, or on line 276 or later when `palMode`=1.
- R10: Settings that change during a field take effect only at the next field sync.
- R11: Where windows overlap, the one with the lowest index is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hSync | input | 1 | One-cycle line-start pulse |
| vSync | input | 1 | One-cycle field-start pulse; also starts line 0 |
| chanEn | input | 1 | Channel enable |
| palMode | input | 1 | 1 = doubled height and 276-line area |
| rowCount | input | 2 | Number of rows shown minus one |
| picWidth | input | 8 | Window width in units of 4 pixels |
| picHeight | input | 8 | Window height in lines (doubled in PAL mode) |
| rowDist | input | 8 | Line distance between row tops |
| rowPitch | input | 32 | Per-row pitch in units of 4 pixels, row r in bits 8r+7:8r |
| rowOffset | input | 8 | Per-row first grid slot, row r in bits 2r+1:2r |
| rowRepeat | input | 8 | Per-row count of extra windows, row r in bits 2r+1:2r |
| winActive | output | 1 | Current pixel is inside a window |
| winIndex | output | 4 | Index of the reported window, row×4+slot |
| winX | output | 12 | Pixel offset inside the window |
| winY | output | 11 | Line offset inside the window |

## Verification
The bench targets these corner cases:

- **Slot clipping.** A row whose offset plus repeat passes slot 3 is tested. A design that failed to clip would draw a phantom fifth window to the right.
- **Overlapping windows.** Windows are made to overlap both within a row and between rows. A wrong priority order would report a higher index and a wrong `winX`/`winY` in the overlap.
- **Area cutoff.** A PAL row is placed so that it straddles line 276, and an NTSC field runs past line 228. Both cutoffs are checked, along with the doubled window height.
- **Mid-field change.** Every setting is changed in the middle of a field. The bench checks that nothing moves until the next field sync, and that a disabled channel stays dark.

// File: rtl/pip_grid_pkg.sv
package pip_grid_pkg;
  localparam int ROWS       = 4;
  localparam int GRID       = 4;
  localparam int XW         = 12;
  localparam int YW         = 11;
  localparam int NTSC_LINES = 228;
  localparam int PAL_LINES  = 276;

  typedef struct packed {
    logic fieldStart;
    logic lineStart;
    logic lineAdvance;
  } strobe_t;

  typedef struct packed {
    logic                 chanEn;
    logic                 palMode;
    logic [1:0]           rowCount;
    logic [7:0]           picWidth;
    logic [7:0]           picHeight;
    logic [7:0]           rowDist;
    logic [ROWS-1:0][7:0] rowPitch;
    logic [ROWS-1:0][1:0] rowOffset;
    logic [ROWS-1:0][1:0] rowRepeat;
  } cfg_t;
endpackage

// File: rtl/pip_grid_ctrl.sv
module pip_grid_ctrl
  import pip_grid_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hSync,
  input  logic    vSync,
  input  cfg_t    cfgIn,
  output strobe_t strb,
  output cfg_t    cfgS
);
  always_comb begin
    strb.fieldStart  = vSync;
    strb.lineStart   = vSync | hSync;
    strb.lineAdvance = hSync & ~vSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cfgS <= '0;
    else if (strb.fieldStart) cfgS <= cfgIn;
  end

  // R10: the latched settings stay put between field syncs
  a_r10_shadow_hold: assert property (@(posedge clk) disable iff (!rstN)
    !vSync |=> $stable(cfgS));
endmodule

// File: rtl/pip_grid_dp.sv
module pip_grid_dp
  import pip_grid_pkg::*;
#(
  parameter int NROW = ROWS,
  parameter int NGRD = GRID,
  parameter int XWID = XW,
  parameter int YWID = YW
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  strobe_t                             strb,
  input  cfg_t                                cfg,
  output logic                                winActive,
  output logic [$clog2(NROW*NGRD)-1:0]        winIndex,
  output logic [XWID-1:0]                     winX,
  output logic [YWID-1:0]                     winY
);
  localparam int NWIN = NROW * NGRD;
  localparam int IW   = $clog2(NWIN);
  localparam logic [XWID-1:0] XMAX = '1;
  localparam logic [YWID-1:0] YMAX = '1;

  logic [XWID-1:0] xCnt;
  logic [YWID-1:0] yCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xCnt <= '0;
      yCnt <= '0;
    end else begin
      if (strb.lineStart)   xCnt <= '0;
      else if (xCnt != XMAX) xCnt <= xCnt + 1'b1;
      if (strb.fieldStart)  yCnt <= '0;
      else if (strb.lineAdvance && yCnt != YMAX) yCnt <= yCnt + 1'b1;
    end
  end

  logic [YWID-1:0] limitY;
  logic [YWID-1:0] heightL;
  logic [XWID:0]   widthP;

  always_comb begin
    limitY  = cfg.palMode ? YWID'(PAL_LINES) : YWID'(NTSC_LINES);
    heightL = cfg.palMode ? YWID'({cfg.picHeight, 1'b0}) : YWID'(cfg.picHeight);
    widthP  = (XWID+1)'({cfg.picWidth, 2'b00});
  end

  logic [NROW-1:0][YWID-1:0] topY;
  logic [NROW-1:0]           rowOn;
  logic [NWIN-1:0][XWID-1:0] startX;
  logic [NWIN-1:0]           hit;

  for (genvar r = 0; r < NROW; r++) begin : g_row
    logic [YWID:0] botY;
    assign topY[r] = YWID'(r * int'(cfg.rowDist));
    assign botY    = {1'b0, topY[r]} + {1'b0, heightL};
    assign rowOn[r] = cfg.chanEn && (r <= int'(cfg.rowCount)) &&
                      (yCnt >= topY[r]) && ({1'b0, yCnt} < botY) &&
                      (yCnt < limitY);
    for (genvar g = 0; g < NGRD; g++) begin : g_slot
      logic [2:0]    lastSlot;
      logic          slotOn;
      logic [XWID:0] endX;
      assign lastSlot = {1'b0, cfg.rowOffset[r]} + {1'b0, cfg.rowRepeat[r]};
      assign slotOn   = (g >= int'(cfg.rowOffset[r])) && (g <= int'(lastSlot));
      assign startX[r*NGRD+g] = XWID'(g * 4 * int'(cfg.rowPitch[r]));
      assign endX     = {1'b0, startX[r*NGRD+g]} + widthP;
      assign hit[r*NGRD+g] = rowOn[r] && slotOn &&
                             (xCnt >= startX[r*NGRD+g]) && ({1'b0, xCnt} < endX);
    end
  end

  logic          anyHit;
  logic [IW-1:0] selIdx;

  always_comb begin
    anyHit = 1'b0;
    selIdx = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        anyHit = 1'b1;
        selIdx = IW'(i);
      end
    end
  end

  always_comb begin
    winActive = anyHit;
    winIndex  = anyHit ? selIdx : '0;
    winX      = anyHit ? xCnt - startX[selIdx] : '0;
    winY      = anyHit ? yCnt - topY[int'(selIdx) / NGRD] : '0;
  end

  a_r8_disabled_dark: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.chanEn |-> !winActive);
  a_r9_area_cutoff: assert property (@(posedge clk) disable iff (!rstN)
    (yCnt >= limitY) |-> !winActive);
  a_r3_width_bound: assert property (@(posedge clk) disable iff (!rstN)
    winActive |-> ({1'b0, winX} < widthP));
  a_r4_height_bound: assert property (@(posedge clk) disable iff (!rstN)
    winActive |-> (winY < heightL));
  a_r7_row_limit: assert property (@(posedge clk) disable iff (!rstN)
    winActive |-> ((int'(winIndex) / NGRD) <= int'(cfg.rowCount)));
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !winActive |-> (winIndex == '0 && winX == '0 && winY == '0));
endmodule

// File: rtl/pip_grid_gen.sv
module pip_grid_gen
  import pip_grid_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hSync,
  input  logic        vSync,
  input  logic        chanEn,
  input  logic        palMode,
  input  logic [1:0]  rowCount,
  input  logic [7:0]  picWidth,
  input  logic [7:0]  picHeight,
  input  logic [7:0]  rowDist,
  input  logic [31:0] rowPitch,
  input  logic [7:0]  rowOffset,
  input  logic [7:0]  rowRepeat,
  output logic        winActive,
  output logic [3:0]  winIndex,
  output logic [11:0] winX,
  output logic [10:0] winY
);
  cfg_t    cfgIn;
  cfg_t    cfgS;
  strobe_t strb;

  always_comb begin
    cfgIn.chanEn    = chanEn;
    cfgIn.palMode   = palMode;
    cfgIn.rowCount  = rowCount;
    cfgIn.picWidth  = picWidth;
    cfgIn.picHeight = picHeight;
    cfgIn.rowDist   = rowDist;
    cfgIn.rowPitch  = rowPitch;
    cfgIn.rowOffset = rowOffset;
    cfgIn.rowRepeat = rowRepeat;
  end

  pip_grid_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .hSync (hSync),
    .vSync (vSync),
    .cfgIn (cfgIn),
    .strb  (strb),
    .cfgS  (cfgS)
  );

  pip_grid_dp #(
    .NROW (ROWS),
    .NGRD (GRID),
    .XWID (XW),
    .YWID (YW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cfg       (cfgS),
    .winActive (winActive),
    .winIndex  (winIndex),
    .winX      (winX),
    .winY      (winY)
  );
endmodule

// File: tb/tb_pip_grid_gen.sv
`timescale 1ns/1ps
module tb_pip_grid_gen;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN, hSync, vSync, chanEn, palMode;
  logic [1:0]  rowCount;
  logic [7:0]  picWidth, picHeight, rowDist, rowOffset, rowRepeat;
  logic [31:0] rowPitch;
  logic        winActive;
  logic [3:0]  winIndex;
  logic [11:0] winX;
  logic [10:0] winY;

  pip_grid_gen dut (.*);

  typedef struct { bit act; int idx; int cx; int cy; string tag; } exp_t;
  exp_t q[$];
  int nVec = 0, nBad = 0;
  bit done = 0;

  int mx = 0, my = 0;
  bit seenV = 0, mEn = 0, mPal = 0;
  int mRows = 1, mW = 0, mH = 0, mDist = 0;
  int mPitch[4], mOff[4], mRep[4];
  string phase = "";

  function automatic exp_t model();
    exp_t e;
    e.act = 0; e.idx = 0; e.cx = 0; e.cy = 0;
    if (!seenV) begin e.tag = "R1 reset state"; return e; end
    if (!mEn) e.tag = "R8 channel off";
    else if (my >= (mPal ? 276 : 228)) e.tag = "R9 outside area";
    else begin
      e.tag = "R3 R4 R6 R7 outside windows";
      for (int r = 0; r < mRows; r++) begin
        int top = r * mDist;
        int h = mPal ? 2 * mH : mH;
        if (my >= top && my < top + h) begin
          for (int g = mOff[r]; g <= mOff[r] + mRep[r] && g <= 3; g++) begin
            int st = g * 4 * mPitch[r];
            if (!e.act && mx >= st && mx < st + 4 * mW) begin
              e.act = 1; e.idx = r * 4 + g; e.cx = mx - st; e.cy = my - top;
              e.tag = "R2 R5 R11 window hit";
            end
          end
        end
      end
    end
    e.tag = {phase, e.tag};
    return e;
  endfunction

  task automatic tick(bit hs, bit vs);
    @(negedge clk);
    hSync = hs; vSync = vs;
    @(posedge clk);
    #1;
    if (vs) begin
      mx = 0; my = 0; seenV = 1;
      mEn = chanEn; mPal = palMode; mRows = int'(rowCount) + 1;
      mW = picWidth; mH = picHeight; mDist = rowDist;
      for (int r = 0; r < 4; r++) begin
        mPitch[r] = rowPitch[8*r +: 8];
        mOff[r] = rowOffset[2*r +: 2];
        mRep[r] = rowRepeat[2*r +: 2];
      end
    end else if (hs) begin
      mx = 0; if (my < 2047) my++;
    end else if (mx < 4095) mx++;
    q.push_back(model());
  endtask

  // monitor: pop and compare once per cycle, away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      nVec++;
      if (winActive !== e.act || int'(winIndex) != e.idx ||
          int'(winX) != e.cx || int'(winY) != e.cy) begin
        nBad++;
        $display("FAIL %s at x=%0d y=%0d: got act=%0b idx=%0d x=%0d y=%0d, expected act=%0b idx=%0d x=%0d y=%0d",
                 e.tag, mx, my, winActive, winIndex, winX, winY, e.act, e.idx, e.cx, e.cy);
      end
    end
  end

  task automatic applyLate();
    palMode = 0; rowCount = 1; picWidth = 2; picHeight = 30; rowDist = 200;
    rowPitch = {8'd0, 8'd0, 8'd4, 8'd3};
    rowOffset = {2'd0, 2'd0, 2'd1, 2'd0};
    rowRepeat = {2'd0, 2'd0, 2'd2, 2'd1};
  endtask

  task automatic runField(int lines, int changeAt);
    tick(0, 1);
    for (int k = 1; k < 40; k++) tick(0, 0);
    for (int l = 1; l < lines; l++) begin
      if (l == changeAt) begin
        phase = "R10 ";
        applyLate();
      end
      tick(1, 0);
      for (int k = 1; k < 40; k++) tick(0, 0);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog R1-independent: got hang, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 0; hSync = 0; vSync = 0; chanEn = 1; palMode = 0; rowCount = 1;
    picWidth = 2; picHeight = 4; rowDist = 10;
    rowPitch = {8'd0, 8'd0, 8'd5, 8'd3};
    rowOffset = {2'd0, 2'd0, 2'd0, 2'd1};
    rowRepeat = {2'd0, 2'd0, 2'd0, 2'd3};
    repeat (3) @(posedge clk);
    @(negedge clk);
    nVec++;
    if (winActive !== 1'b0 || winIndex != 0 || winX != 0 || winY != 0) begin
      nBad++;
      $display("FAIL R1 in reset: got act=%0b idx=%0d x=%0d y=%0d, expected all 0",
               winActive, winIndex, winX, winY);
    end
    rstN = 1;
    // R1: before the first field sync nothing shows
    for (int k = 0; k < 20; k++) tick(k == 10, 0);
    // NTSC, two rows, slot clipping on row 0 (R6)
    runField(40, -1);
    // R8: same settings with channel disabled
    chanEn = 0;
    runField(30, -1);
    // PAL, four rows, overlaps (R11), straddling line 276 (R9, R4)
    chanEn = 1; palMode = 1; rowCount = 3; picWidth = 3; picHeight = 40; rowDist = 70;
    rowPitch = {8'd4, 8'd1, 8'd3, 8'd2};
    rowOffset = {2'd0, 2'd3, 2'd2, 2'd0};
    rowRepeat = {2'd1, 2'd0, 2'd3, 2'd3};
    runField(300, 100);
    // R10: late settings now take effect; NTSC cutoff at 228 (R9)
    phase = "";
    runField(240, -1);
    @(negedge clk);
    #1;
    done = 1;
    summary();
    $finish;
  end
endmodule